// File: doc/BRIEF.md
# Command/Indication Change Detector

This block watches the upstream side of a time-division frame in which time slots are grouped in pairs. Only a pair that starts on an even slot counts, and its 4-bit command/indication code travels in the odd slot of the pair. The block keeps the latest odd-slot code of each pair. On every frame-start strobe it takes a snapshot of all pairs at once. It then walks the pairs one per clock and compares each enabled pair's snapshot with the code it stored for that pair. The stored codes are kept under the address of the even slot.

When a pair's code differs from its stored code, the block updates the stored code and raises an interrupt flag. It also queues the even-slot address in an 8-entry FIFO. Each queued entry has bit 7 set. The same bit selects the upstream direction on the read port, so a processor can pop an entry and use it unchanged as the address of the next memory read. A single registered read port serves three sources: stored codes, FIFO pops and a status word.

Top module: `ci_watch`

## Requirements
- R1: The code on `rx_code` is captured for pair p only when `rx_vld` is high and `rx_slot` equals 2p+1. Codes offered in even slots are ignored.
- R2: A memory read (`rd_sel`=0) at address {1'b1, 2'b00, even slot} returns {4'h0, stored code of that pair}. A read returns 8'h00 when bit 7 is 0, when bit 0 is 1, or when bits 6:5 are nonzero.
- R3: A `frame_sync` seen while the block is idle snapshots every pair's captured code. Pair i is then compared and updated at the (i+1)-th clock edge after the strobe edge. A `frame_sync` that arrives during a scan is ignored.
- R4: A pair whose bit in `en_pairs` is 0 keeps its stored code and never queues an entry.
- R5: When an enabled pair's snapshot differs from its stored code, the stored code takes the new value. The entry {1'b1, 2'b00, even slot} is also queued, and entries from one frame come out in ascending pair order.
- R6: An enabled pair whose snapshot equals its stored code queues nothing.
- R7: A FIFO pop (`rd_sel`=1) on an empty FIFO returns 8'h00.
- R8: The FIFO holds 8 entries. A change found while it is full still updates the stored code, but its entry is dropped. A drop sets a sticky overflow flag, which reads as status bit 1 and is cleared by a status read.
- R9: Every change sets an interrupt flag, which reads as status bit 0 and is cleared by a status read (`rd_sel`=2). The `irq` output is high whenever this flag is set or the FIFO is non-empty.
- R10: `rd_data` is loaded one clock after a cycle with `rd_en` high and holds its value while `rd_en` stays low.
- R11: After reset all stored codes are 0, the FIFO is empty, both flags are clear, and `rd_data` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sync | input | 1 | One-cycle frame-start strobe that starts a sampling pass |
| rx_vld | input | 1 | Received slot data valid |
| rx_slot | input | 5 | Slot number of the received data |
| rx_code | input | 4 | Received 4-bit code |
| en_pairs | input | 16 | Per-pair monitor enable, bit p for slots 2p/2p+1 |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 2 | Read source: 0 memory, 1 FIFO pop, 2 status |
| rd_addr | input | 8 | Memory read address: bit 7 upstream, low bits slot |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Interrupt: flag set or FIFO non-empty |

## Verification
A read result appears one edge after the `rd_en` edge. The bench raises `rd_en` on a falling edge and reads `rd_data` on the next falling edge. The effect of a frame strobe on pair i is complete i+1 edges after the strobe edge, so the bench waits 17 falling edges after releasing `frame_sync` before it looks at FIFO, status or memory. The `irq` output follows the FIFO and flag registers in the same edge that changes them, and the bench samples it only at falling edges between transactions.

// File: rtl/ci_watch_pkg.sv
package ci_watch_pkg;

  localparam int unsigned RD_W = 8;

  typedef enum logic [1:0] {
    SEL_MEM  = 2'd0,
    SEL_FIFO = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;

  // queue entry: valid/upstream flag in bit 7, even slot number below
  function automatic logic [RD_W-1:0] ci_entry(input logic [RD_W-2:0] slot);
    return {1'b1, slot};
  endfunction

  // memory address accepted: upstream, even slot, no bits above the slot field
  function automatic logic ci_addr_ok(input logic [RD_W-1:0] a, input int unsigned slot_w);
    logic [RD_W-1:0] hi;
    hi = 8'h7F & ~((8'h01 << slot_w) - 8'h01);
    return a[RD_W-1] && !a[0] && ((a & hi) == 8'h00);
  endfunction

endpackage

// File: rtl/ci_rx_capture.sv
module ci_rx_capture #(
  parameter int unsigned NUM_PAIRS = 16,
  parameter int unsigned CODE_W    = 4,
  localparam int unsigned PAIR_W   = $clog2(NUM_PAIRS),
  localparam int unsigned SLOT_W   = PAIR_W + 1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 rx_vld,
  input  logic [SLOT_W-1:0]                    rx_slot,
  input  logic [CODE_W-1:0]                    rx_code,
  output logic [NUM_PAIRS-1:0][CODE_W-1:0]     cap_codes
);

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    logic hit;
    assign hit = rx_vld && (rx_slot == SLOT_W'(2 * g + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cap_codes[g] <= '0;
      else if (hit) cap_codes[g] <= rx_code;
    end
  end

endmodule

// File: rtl/ci_scan.sv
module ci_scan #(
  parameter int unsigned NUM_PAIRS = 16,
  parameter int unsigned CODE_W    = 4,
  localparam int unsigned PAIR_W   = $clog2(NUM_PAIRS),
  localparam int unsigned SLOT_W   = PAIR_W + 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             frame_sync,
  input  logic [NUM_PAIRS-1:0][CODE_W-1:0] cap_codes,
  input  logic [NUM_PAIRS-1:0]             en_pairs,
  output logic [NUM_PAIRS-1:0][CODE_W-1:0] stored,
  output logic                             busy,
  output logic                             push_evt,
  output logic [SLOT_W-1:0]                push_slot
);

  logic [NUM_PAIRS-1:0][CODE_W-1:0] snap;
  logic [PAIR_W-1:0]                idx;
  logic                             last;
  logic                             differs;

  assign last      = (idx == PAIR_W'(NUM_PAIRS - 1));
  assign differs   = (snap[idx] != stored[idx]);
  assign push_evt  = busy && en_pairs[idx] && differs;
  assign push_slot = {idx, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap   <= '0;
      stored <= '0;
      busy   <= 1'b0;
      idx    <= '0;
    end else if (!busy) begin
      if (frame_sync) begin
        snap <= cap_codes;
        busy <= 1'b1;
        idx  <= '0;
      end
    end else begin
      if (push_evt) stored[idx] <= snap[idx];
      idx <= last ? '0 : idx + 1'b1;
      if (last) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/ci_addr_fifo.sv
module ci_addr_fifo #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              empty,
  output logic              full,
  output logic              drop,
  output logic [CNT_W-1:0]  count
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic              do_push, do_pop;

  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign do_pop   = pop && !empty;
  assign do_push  = push && (!full || do_pop);
  assign drop     = push && !do_push;
  assign pop_data = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wp] <= push_data;
        wp      <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (do_pop) rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/ci_watch.sv
module ci_watch
  import ci_watch_pkg::*;
#(
  parameter int unsigned NUM_PAIRS  = 16,
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned FIFO_DEPTH = 8,
  localparam int unsigned PAIR_W    = $clog2(NUM_PAIRS),
  localparam int unsigned SLOT_W    = PAIR_W + 1,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_sync,
  input  logic                 rx_vld,
  input  logic [SLOT_W-1:0]    rx_slot,
  input  logic [CODE_W-1:0]    rx_code,
  input  logic [NUM_PAIRS-1:0] en_pairs,
  input  logic                 rd_en,
  input  logic [1:0]           rd_sel,
  input  logic [RD_W-1:0]      rd_addr,
  output logic [RD_W-1:0]      rd_data,
  output logic                 irq
);

  logic [NUM_PAIRS-1:0][CODE_W-1:0] cap_codes;
  logic [NUM_PAIRS-1:0][CODE_W-1:0] stored;
  logic                             scan_busy;
  logic                             push_evt;
  logic [SLOT_W-1:0]                push_slot;
  logic [RD_W-1:0]                  fifo_head;
  logic                             fifo_empty, fifo_full, drop_evt;
  logic [CNT_W-1:0]                 fifo_count;
  logic                             fifo_pop, stat_rd;
  logic                             ovf_q, flag_q;
  logic [RD_W-1:0]                  rd_next;
  logic [PAIR_W-1:0]                rd_pair;

  ci_rx_capture #(.NUM_PAIRS(NUM_PAIRS), .CODE_W(CODE_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_slot(rx_slot),
    .rx_code(rx_code), .cap_codes(cap_codes)
  );

  ci_scan #(.NUM_PAIRS(NUM_PAIRS), .CODE_W(CODE_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .cap_codes(cap_codes),
    .en_pairs(en_pairs), .stored(stored), .busy(scan_busy),
    .push_evt(push_evt), .push_slot(push_slot)
  );

  ci_addr_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(RD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_evt),
    .push_data(ci_entry((RD_W-1)'(push_slot))), .pop(fifo_pop),
    .pop_data(fifo_head), .empty(fifo_empty), .full(fifo_full),
    .drop(drop_evt), .count(fifo_count)
  );

  assign fifo_pop = rd_en && (rd_sel == SEL_FIFO);
  assign stat_rd  = rd_en && (rd_sel == SEL_STAT);
  assign rd_pair  = rd_addr[SLOT_W-1:1];
  assign irq      = flag_q || !fifo_empty;

  always_comb begin
    case (rd_sel)
      SEL_MEM:  rd_next = ci_addr_ok(rd_addr, SLOT_W) ? RD_W'(stored[rd_pair]) : '0;
      SEL_FIFO: rd_next = fifo_empty ? '0 : fifo_head;
      SEL_STAT: rd_next = {6'b0, ovf_q, flag_q};
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      ovf_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_next;
      if (drop_evt)     ovf_q <= 1'b1;
      else if (stat_rd) ovf_q <= 1'b0;
      if (push_evt)     flag_q <= 1'b1;
      else if (stat_rd) flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/ci_watch_chk.sv
module ci_watch_chk #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic [1:0]       rd_sel,
  input logic [7:0]       rd_data,
  input logic             irq,
  input logic             push_evt,
  input logic             drop_evt,
  input logic             ovf_q,
  input logic             stat_rd,
  input logic             fifo_empty,
  input logic [CNT_W-1:0] fifo_count,
  input logic             scan_busy
);

  AST_IRQ_WHILE_QUEUED: assert property (@(posedge clk) disable iff (!rst_n) !fifo_empty |-> irq); // R9
  AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n) drop_evt |=> ovf_q); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovf_q && !stat_rd) |=> ovf_q); // R8
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) fifo_count <= CNT_W'(DEPTH)); // R8
  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == 2'd1 && fifo_empty) |=> rd_data == 8'h00); // R7
  AST_ENTRY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == 2'd1 && !fifo_empty) |=> rd_data[7]); // R5
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> $stable(rd_data)); // R10
  AST_PUSH_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n) push_evt |-> scan_busy); // R3

endmodule

bind ci_watch ci_watch_chk #(.CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
  .irq(irq), .push_evt(push_evt), .drop_evt(drop_evt), .ovf_q(ovf_q),
  .stat_rd(stat_rd), .fifo_empty(fifo_empty), .fifo_count(fifo_count),
  .scan_busy(scan_busy)
);

// File: tb/test_ci_watch.sv
`timescale 1ns/1ps
module test_ci_watch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_sync = 1'b0;
  logic        rx_vld = 1'b0;
  logic [4:0]  rx_slot = '0;
  logic [3:0]  rx_code = '0;
  logic [15:0] en_pairs = 16'hFFDF;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] model [16];

  always #2.5 clk = ~clk;

  ci_watch i_ci_watch (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rx_vld(rx_vld),
    .rx_slot(rx_slot), .rx_code(rx_code), .en_pairs(en_pairs), .rd_en(rd_en),
    .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // vector: pair[8:5], code[4:1], change expected[0]
  localparam logic [8:0] VEC [10] = '{
    {4'd0, 4'h3, 1'b1}, {4'd0, 4'h3, 1'b0}, {4'd0, 4'hA, 1'b1},
    {4'd7, 4'hF, 1'b1}, {4'd5, 4'h9, 1'b0}, {4'd15, 4'h1, 1'b1},
    {4'd7, 4'hF, 1'b0}, {4'd3, 4'h0, 1'b0}, {4'd3, 4'h6, 1'b1},
    {4'd15, 4'hE, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rx(input logic [4:0] slot, input logic [3:0] code);
    @(negedge clk);
    rx_vld = 1'b1; rx_slot = slot; rx_code = code;
    @(negedge clk);
    rx_vld = 1'b0;
  endtask

  task automatic pulse_sync();
    @(negedge clk);
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
  endtask

  task automatic frame();
    pulse_sync();
    repeat (17) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] sel, input logic [7:0] addr, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel; rd_addr = addr;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [7:0] ent(input int p);
    return 8'h80 | 8'(2 * p);
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < 16; i++) model[i] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 rd_data", rd_data, 8'h00);
    chk("R11 irq", {7'b0, irq}, 8'h00);
    rd(2'd2, 8'h00, d); chk("R11 status", d, 8'h00);
    rd(2'd0, 8'h80, d); chk("R11 mem pair0", d, 8'h00);

    // table walk: R5 R6 R4 R2 R9
    for (int v = 0; v < 10; v++) begin
      int p;
      logic [3:0] c;
      logic ch;
      p  = int'(VEC[v][8:5]);
      c  = VEC[v][4:1];
      ch = VEC[v][0];
      if (en_pairs[p] && model[p] != c) model[p] = c;
      rx(5'(2 * p + 1), c);
      frame();
      chk(ch ? "R9 irq on change" : "R6 irq quiet", {7'b0, irq}, {7'b0, ch});
      rd(2'd1, 8'h00, d);
      chk(ch ? "R5 entry" : (p == 5 ? "R4 disabled no entry" : "R6 no entry"), d, ch ? ent(p) : 8'h00);
      rd(2'd2, 8'h00, d); chk("R9 status flag", d, {7'b0, ch});
      chk("R9 irq cleared", {7'b0, irq}, 8'h00);
      rd(2'd0, ent(p), d); chk(p == 5 ? "R4 stored kept" : "R2 mem read", d, {4'h0, model[p]});
    end

    // R1 even slot ignored
    rx(5'd4, 4'h9);
    frame();
    rd(2'd1, 8'h00, d); chk("R1 even slot no entry", d, 8'h00);
    rd(2'd0, ent(2), d); chk("R1 even slot not stored", d, 8'h00);

    // R2 rejected addresses
    rd(2'd0, 8'h81, d); chk("R2 odd address", d, 8'h00);
    rd(2'd0, 8'h00, d); chk("R2 direction bit 0", d, 8'h00);
    rd(2'd0, 8'hA0, d); chk("R2 high bits", d, 8'h00);
    rd(2'd0, 8'h80, d); chk("R2 pair0 value", d, 8'h0A);

    // R3 strobe during scan ignored
    rx(5'd31, 4'h2);
    pulse_sync();
    rx(5'd31, 4'h4);
    pulse_sync();
    repeat (20) @(negedge clk);
    rd(2'd0, ent(15), d); chk("R3 snapshot value", d, 8'h02);
    rd(2'd1, 8'h00, d); chk("R3 one entry", d, ent(15));
    rd(2'd1, 8'h00, d); chk("R3 second strobe ignored", d, 8'h00);
    frame();
    rd(2'd0, ent(15), d); chk("R3 next frame value", d, 8'h04);
    rd(2'd1, 8'h00, d); chk("R3 next frame entry", d, ent(15));
    rd(2'd2, 8'h00, d);

    // R8 overflow: nine changes in one frame
    for (int p = 0; p < 10; p++) if (p != 5) rx(5'(2 * p + 1), 4'h5);
    frame();
    rd(2'd2, 8'h00, d); chk("R8 ovf and flag", d, 8'h03);
    chk("R9 irq while queued", {7'b0, irq}, 8'h01);
    rd(2'd2, 8'h00, d); chk("R8 ovf cleared", d, 8'h00);
    for (int p = 0; p < 9; p++) begin
      if (p != 5) begin
        rd(2'd1, 8'h00, d); chk("R5 ascending order", d, ent(p));
      end
    end
    rd(2'd1, 8'h00, d); chk("R7 empty pop", d, 8'h00);
    chk("R9 irq low when drained", {7'b0, irq}, 8'h00);
    rd(2'd0, ent(9), d); chk("R8 dropped pair still stored", d, 8'h05);

    // R10 hold
    repeat (5) @(negedge clk);
    chk("R10 rd_data holds", rd_data, 8'h05);

    finish_run();
  end

endmodule